// File: doc/BRIEF.md
# Power-up calibration and ADC data-valid sequencer

This block sequences a stereo audio converter interface out of reset and out of power-down. On every exit it counts frames through a fixed calibration window and then a window for the digital filters to settle. Only after both windows have passed does it raise the ADC data-valid flag. Until then it replaces every ADC sample word with zero. The DAC mute is held for as long as calibration runs. Frames are counted only on a one-cycle frame strobe. Reset or power-down, asserted at any moment, drops validity at once and restarts the count from zero.

The ADC samples flow through the block on a valid/ready stream. The path holds no storage: `m_valid` follows `s_valid` and `s_ready` follows `m_ready` in the same cycle, so back-pressure from the sink reaches the source without delay. A word is transferred in a cycle where both valid and ready are high. The block only zeroes the data of invalid words and never stalls or drops a transfer.

On reset the block pulses a control-register clear and drives its data outputs low. On power-down it drives the data outputs low at once, and one clock later it removes the output enable that a pad ring uses to float them.

Top module: `calval_seq`

## Requirements
- R1: While `rst_n` is low: `adc_ok`=0, `dac_mute`=1, `ctrl_clear`=1, `dout_oe`=1, and `m_left`/`m_right` are 0.
- R2: `ctrl_clear` falls at the first rising clock edge that samples `rst_n` high.
- R3: After exit from reset or power-down, `dac_mute` stays 1 until the edge that counts the CAL_FRAMES-th frame strobe (default 194), and is 0 from then on while powered up.
- R4: Until CAL_FRAMES+LAT_FRAMES strobes (default 194+32) have been counted, `adc_ok`=0 and both output words are 0.
- R5: `adc_ok` rises at the edge that counts strobe number CAL_FRAMES+LAT_FRAMES. From then on `m_left`/`m_right` equal `s_left`/`s_right`.
- R6: A clock cycle with `frame_stb`=0 does not advance the sequence.
- R7: After `adc_ok` has risen, further strobes leave `adc_ok`=1 and `dac_mute`=0, because the count saturates.
- R8: With `pdn_n` low, `adc_ok` is 0 and the words are 0 in the same cycle, `dac_mute` is 1, and `dout_oe` falls at the next rising edge. Releasing `pdn_n` restarts the full count.
- R9: Reset asserted in the middle of a sequence restarts the full count from zero.
- R10: In every phase, `m_valid`=`s_valid` and `s_ready`=`m_ready` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Synchronous active-low power-down |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| s_valid | input | 1 | ADC sample stream valid |
| s_ready | output | 1 | ADC sample stream ready |
| s_left | input | SMP_W | Raw left ADC sample |
| s_right | input | SMP_W | Raw right ADC sample |
| m_valid | output | 1 | Gated sample stream valid |
| m_ready | input | 1 | Gated sample stream ready |
| m_left | output | SMP_W | Left sample, zero while invalid |
| m_right | output | SMP_W | Right sample, zero while invalid |
| adc_ok | output | 1 | ADC data-valid flag |
| dac_mute | output | 1 | DAC mute |
| ctrl_clear | output | 1 | Clear for the control registers |
| dout_oe | output | 1 | Output enable for the digital outputs |

## Verification
The stream handshake, the gated words and the immediate effect of power-down are combinational. They are due in the same cycle as their stimulus, and one direct check samples them before any clock edge. The frame count, and with it `adc_ok` and `dac_mute`, changes at the rising edge that samples a strobe. `ctrl_clear` and `dout_oe` change at the rising edge after a change on `rst_n` or `pdn_n`. The driver applies each cycle's inputs at the falling edge and queues the outputs expected after the next rising edge. The monitor compares them 1 ns after that edge, so every register on the path has already updated.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic [1:0] {
    PH_CAL = 2'd0,
    PH_LAT = 2'd1,
    PH_RUN = 2'd2
  } cvs_phase_e;
endpackage

// File: rtl/cvs_frame_counter.sv
module cvs_frame_counter
  import cvs_pkg::*;
#(
  parameter int CAL_FRAMES = 194,
  parameter int LAT_FRAMES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pdn_n,
  input  logic       frame_stb,
  output cvs_phase_e phase
);
  localparam int TOT = CAL_FRAMES + LAT_FRAMES;
  localparam int CW  = $clog2(TOT + 1);
  localparam logic [CW-1:0] CAL_END = CW'(CAL_FRAMES);
  localparam logic [CW-1:0] TOT_END = CW'(TOT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!pdn_n) begin
      cnt_q <= '0;
    end else if (frame_stb && (cnt_q != TOT_END)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (cnt_q < CAL_END)      phase = PH_CAL;
    else if (cnt_q < TOT_END) phase = PH_LAT;
    else                      phase = PH_RUN;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && pdn_n) |=> $stable(cnt_q)); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && pdn_n && (cnt_q != TOT_END)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= TOT_END)); // R7
endmodule

// File: rtl/cvs_sample_gate.sv
module cvs_sample_gate #(
  parameter int SMP_W = 16,
  parameter int NCH   = 2
) (
  input  logic                      pass,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [NCH-1:0][SMP_W-1:0] s_data,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic [NCH-1:0][SMP_W-1:0] m_data
);
  assign m_valid = s_valid;
  assign s_ready = m_ready;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign m_data[ch] = pass ? s_data[ch] : '0;
  end
endmodule

// File: rtl/cvs_pad_ctrl.sv
module cvs_pad_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_n,
  output logic ctrl_clear,
  output logic dout_oe
);
  logic clr_q;
  logic oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      clr_q <= 1'b0;
      oe_q  <= pdn_n;
    end
  end

  assign ctrl_clear = clr_q;
  assign dout_oe    = oe_q;

  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clear |=> !ctrl_clear); // R2
endmodule

// File: rtl/calval_seq.sv
module calval_seq
  import cvs_pkg::*;
#(
  parameter int SMP_W      = 16,
  parameter int CAL_FRAMES = 194,
  parameter int LAT_FRAMES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdn_n,
  input  logic             frame_stb,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SMP_W-1:0] s_left,
  input  logic [SMP_W-1:0] s_right,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [SMP_W-1:0] m_left,
  output logic [SMP_W-1:0] m_right,
  output logic             adc_ok,
  output logic             dac_mute,
  output logic             ctrl_clear,
  output logic             dout_oe
);
  cvs_phase_e              phase;
  logic [1:0][SMP_W-1:0]   in_words;
  logic [1:0][SMP_W-1:0]   out_words;

  cvs_frame_counter #(
    .CAL_FRAMES(CAL_FRAMES),
    .LAT_FRAMES(LAT_FRAMES)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdn_n    (pdn_n),
    .frame_stb(frame_stb),
    .phase    (phase)
  );

  assign adc_ok   = (phase == PH_RUN) && pdn_n;
  assign dac_mute = (phase == PH_CAL) || !pdn_n;

  assign in_words[0] = s_left;
  assign in_words[1] = s_right;

  cvs_sample_gate #(
    .SMP_W(SMP_W),
    .NCH  (2)
  ) u_gate (
    .pass   (adc_ok),
    .s_valid(s_valid),
    .s_ready(s_ready),
    .s_data (in_words),
    .m_valid(m_valid),
    .m_ready(m_ready),
    .m_data (out_words)
  );

  assign m_left  = out_words[0];
  assign m_right = out_words[1];

  cvs_pad_ctrl u_pad (
    .clk       (clk),
    .rst_n     (rst_n),
    .pdn_n     (pdn_n),
    .ctrl_clear(ctrl_clear),
    .dout_oe   (dout_oe)
  );

  AST_OK_UNMUTED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ok |-> !dac_mute); // R5
  AST_ZERO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_ok |-> (m_left == '0 && m_right == '0)); // R4
  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe) |-> (!adc_ok && dac_mute)); // R8
endmodule

// File: tb/tb_calval_seq.sv
`timescale 1ns/1ps
module tb_calval_seq;
  localparam int W   = 16;
  localparam int CAL = 194;
  localparam int LAT = 32;
  localparam int TOT = CAL + LAT;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, pdn_n = 1'b1, frame_stb = 1'b0;
  logic s_valid = 1'b0, m_ready = 1'b0;
  logic [W-1:0] s_left = '0, s_right = '0;
  logic s_ready, m_valid, adc_ok, dac_mute, ctrl_clear, dout_oe;
  logic [W-1:0] m_left, m_right;

  calval_seq #(.SMP_W(W), .CAL_FRAMES(CAL), .LAT_FRAMES(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .frame_stb(frame_stb),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .m_valid(m_valid), .m_ready(m_ready), .m_left(m_left), .m_right(m_right),
    .adc_ok(adc_ok), .dac_mute(dac_mute), .ctrl_clear(ctrl_clear), .dout_oe(dout_oe)
  );

  typedef struct {
    logic ok, mute, clr, oe, mv, sr;
    logic [W-1:0] l, r;
    string tag;
  } exp_t;

  exp_t q[$];
  int nvec = 0, nfail = 0;
  bit done = 0;
  string scen = "R1 reset";
  int m_cnt = 0;
  logic m_clr = 1'b1, m_oe = 1'b1;
  int k = 0;

  task automatic chk1(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: inputs at falling edge, expectation for after next rising edge
  task automatic step(logic rst, logic pdn, logic stb);
    exp_t e;
    logic ok;
    @(negedge clk);
    k++;
    rst_n = rst; pdn_n = pdn; frame_stb = stb;
    s_valid = k[0]; m_ready = k[1];
    s_left = W'(k * 37 + 5); s_right = W'(k * 91 + 3) ^ 16'hA5A5;
    if (!rst) begin
      m_cnt = 0; m_clr = 1'b1; m_oe = 1'b1;
    end else begin
      m_clr = 1'b0;
      m_oe  = pdn;
      if (!pdn) m_cnt = 0;
      else if (stb && m_cnt < TOT) m_cnt++;
    end
    ok = rst && pdn && (m_cnt >= TOT);
    e.ok = ok;
    e.mute = !rst || !pdn || (m_cnt < CAL);
    e.clr = m_clr; e.oe = m_oe;
    e.mv = s_valid; e.sr = m_ready;
    e.l = ok ? s_left : '0;
    e.r = ok ? s_right : '0;
    e.tag = scen;
    q.push_back(e);
  endtask

  // monitor: compare 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        nvec++;
        chk1(e.tag, "adc_ok", W'(adc_ok), W'(e.ok));
        chk1(e.tag, "dac_mute", W'(dac_mute), W'(e.mute));
        chk1(e.tag, "ctrl_clear", W'(ctrl_clear), W'(e.clr));
        chk1(e.tag, "dout_oe", W'(dout_oe), W'(e.oe));
        chk1({e.tag, " R10"}, "m_valid", W'(m_valid), W'(e.mv));
        chk1({e.tag, " R10"}, "s_ready", W'(s_ready), W'(e.sr));
        chk1(e.tag, "m_left", m_left, e.l);
        chk1(e.tag, "m_right", m_right, e.r);
      end
    end
  end

  task automatic run_strobes(int n, int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b1, 1'b1);
      for (int g = 0; g < gap; g++) step(1'b1, 1'b1, 1'b0);
    end
  endtask

  initial begin
    scen = "R1 reset";
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1);
    scen = "R2 clear release";
    step(1'b1, 1'b1, 1'b0);
    scen = "R6 idle no strobe";
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0);
    scen = "R3 R4 calibration";
    run_strobes(CAL, 1);
    scen = "R4 R6 latency";
    for (int i = 0; i < 15; i++) step(1'b1, 1'b1, 1'b0);
    run_strobes(LAT, 2);
    scen = "R5 R7 R10 saturated";
    run_strobes(30, 0);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0);
    // R8 immediate effect before any clock edge
    @(negedge clk);
    pdn_n = 1'b0;
    #1;
    nvec++;
    chk1("R8 immediate", "adc_ok", W'(adc_ok), W'(0));
    chk1("R8 immediate", "dac_mute", W'(dac_mute), W'(1));
    chk1("R8 immediate", "m_left", m_left, '0);
    chk1("R8 immediate", "dout_oe", W'(dout_oe), W'(1));
    scen = "R8 power-down";
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1);
    scen = "R8 restart after power-down";
    run_strobes(TOT + 5, 0);
    scen = "R9 partial run";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
    run_strobes(100, 0);
    scen = "R9 mid-run reset";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1);
    scen = "R9 rerun";
    run_strobes(TOT + 5, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule